// File: doc/BRIEF.md
# Advanced Load Tracking Table

The block is a small fully associative table that remembers which registers were filled by an advanced (early, possibly speculative) load. Each entry records the register number, the physical address and the access size of that load. A later check load for the same register asks the table whether the earlier value is still good. A hit means the memory access may be skipped. A miss means the load pipeline must perform the access again. Stores are snooped against the table, and any entry whose bytes a store touches is dropped. A software-style invalidate port drops an entry by register number.

Four request ports are handled in one clock:
- **allocate:** an advanced load. When its defer flag is set, it purges the entry for its register instead of adding one.
- **check:** a clear or keep flavour, with a non-speculative page input and a global force-miss input.
- **store snoop**
- **invalidate**

The check answer comes back one cycle after the request. The table keeps at most one entry per register. When an allocation needs a slot, it uses the slot already holding that register. Failing that, it takes the lowest free slot. When no slot is free, a round-robin victim pointer picks the slot.

The block is a datapath with no controller states. The only sequencing is the fixed order in which the four same-cycle requests act on the table.

Top module: `ldtrack_table`

## Requirements
- R1: After reset the table is empty and `rsp_valid` is low, so the first check of any register answers with `rsp_skip` = 0.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `chk_valid` high. `rsp_skip` is never high without `rsp_valid`.
- R3: An allocate with `alloc_defer` = 0 records `alloc_rid`, `alloc_addr` and `alloc_lsz`. A later keep check of that register answers `rsp_skip` = 1.
- R4: An allocate with `alloc_defer` = 1 adds nothing and removes any entry held for `alloc_rid`.
- R5: A keep check (`chk_clear` = 0) that hits answers `rsp_skip` = 1 and leaves the entry in place.
- R6: A keep check that misses answers `rsp_skip` = 0. It records a new entry from `chk_rid`, `chk_addr` and `chk_lsz` when `chk_nonspec` = 0, and records nothing when `chk_nonspec` = 1.
- R7: A clear check (`chk_clear` = 1) that hits answers `rsp_skip` = 1 and removes the entry.
- R8: A clear check that misses records nothing. A clear check under forced miss leaves the table unchanged.
- R9: While `force_miss` = 1, every check answers `rsp_skip` = 0, whether or not an entry matches.
- R10: A snoop removes every entry whose byte range overlaps the store's byte range. A range runs from the address to address + 2^lsz - 1, where lsz is 0..3 for 1, 2, 4 or 8 bytes. Entries that do not overlap are kept.
- R11: An invalidate removes the entry for `inv_rid` and leaves the other entries alone.
- R12: The table never holds two entries for one register, and an allocation for a held register overwrites that entry. An allocation uses slots in this priority:
    - the slot already holding the register;
    - otherwise the lowest-index free slot;
    - otherwise the slot named by a victim pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such replacement.
- R13: Requests in one cycle act in a fixed order: snoop and invalidate first, then the check, whose lookup and allocation come before the allocate port's allocation or purge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_miss | input | 1 | Make every check lookup miss |
| alloc_valid | input | 1 | Advanced load request |
| alloc_defer | input | 1 | Load was deferred: purge instead of record |
| alloc_rid | input | 7 | Target register number |
| alloc_addr | input | 64 | Physical address |
| alloc_lsz | input | 2 | Log2 of access size in bytes |
| chk_valid | input | 1 | Check load request |
| chk_clear | input | 1 | 1 = clear flavour, 0 = keep flavour |
| chk_nonspec | input | 1 | Page is non-speculative: no allocation on miss |
| chk_rid | input | 7 | Register being checked |
| chk_addr | input | 64 | Address of the check load |
| chk_lsz | input | 2 | Log2 of check access size |
| snoop_valid | input | 1 | Store snoop request |
| snoop_addr | input | 64 | Store address |
| snoop_lsz | input | 2 | Log2 of store size |
| inv_valid | input | 1 | Invalidate request |
| inv_rid | input | 7 | Register whose entry is dropped |
| rsp_valid | output | 1 | Check answer valid (one cycle after request) |
| rsp_skip | output | 1 | 1 = hit, memory access may be skipped |

## Verification
A wrong internal state shows at the ports only when the affected register is next checked. An entry that should have survived shows up as a miss, which costs performance. An entry that should have gone, through a missed snoop, purge or clear, shows up as a false `rsp_skip`, which corrupts data. Either error shows one cycle after the next check of that register, so the bench uses a small register and address space and checks often. A wrong victim pointer only shows once the table is full. It surfaces as the wrong register missing after a replacement, so the bench fills the table and probes every resident register.

// File: rtl/ldtrack_pkg.sv
package ldtrack_pkg;
    localparam int REG_W  = 7;
    localparam int ADDR_W = 64;
    localparam int SIZE_W = 2;

    typedef struct packed {
        logic [REG_W-1:0]  rid;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] lsz;
    } tag_t;

    // Two byte ranges [a, a+2^sa) and [b, b+2^sb) share at least one byte.
    function automatic logic ranges_meet(
        input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] sa,
        input logic [ADDR_W-1:0] b, input logic [SIZE_W-1:0] sb);
        logic [ADDR_W:0] a_end;
        logic [ADDR_W:0] b_end;
        a_end = {1'b0, a} + ({{ADDR_W{1'b0}}, 1'b1} << sa);
        b_end = {1'b0, b} + ({{ADDR_W{1'b0}}, 1'b1} << sb);
        return ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
    endfunction
endpackage

// File: rtl/ldtrack_slot.sv
module ldtrack_slot
    import ldtrack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_nxt,
    input  logic              ld_a,
    input  logic              ld_b,
    input  tag_t              tag_a,
    input  tag_t              tag_b,
    input  logic [REG_W-1:0]  chk_rid,
    input  logic [REG_W-1:0]  inv_rid,
    input  logic [REG_W-1:0]  alc_rid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [SIZE_W-1:0] snp_lsz,
    output logic              valid_q,
    output tag_t              tag_q,
    output logic              m_chk,
    output logic              m_inv,
    output logic              m_alc,
    output logic              m_snp
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else begin
            valid_q <= valid_nxt;
            if (ld_b)
                tag_q <= tag_b;
            else if (ld_a)
                tag_q <= tag_a;
        end
    end

    always_comb begin
        m_chk = valid_q && (tag_q.rid == chk_rid);
        m_inv = valid_q && (tag_q.rid == inv_rid);
        m_alc = valid_q && (tag_q.rid == alc_rid);
        m_snp = valid_q && ranges_meet(tag_q.addr, tag_q.lsz, snp_addr, snp_lsz);
    end
endmodule

// File: rtl/ldtrack_pick.sv
module ldtrack_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  live,
    input  logic [N-1:0]  same,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  sel_oh,
    output logic          rotate
);
    logic [IW-1:0] idx;
    logic          got_same;
    logic          got_free;

    always_comb begin
        idx      = '0;
        rotate   = 1'b0;
        got_same = 1'b0;
        got_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same[i]) begin
                idx      = IW'(i);
                got_same = 1'b1;
            end
        end
        if (!got_same) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!live[i]) begin
                    idx      = IW'(i);
                    got_free = 1'b1;
                end
            end
            if (!got_free) begin
                idx    = ptr;
                rotate = 1'b1;
            end
        end
        sel_oh      = '0;
        sel_oh[idx] = 1'b1;
    end
endmodule

// File: rtl/ldtrack_table.sv
module ldtrack_table
    import ldtrack_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_miss,
    input  logic              alloc_valid,
    input  logic              alloc_defer,
    input  logic [REG_W-1:0]  alloc_rid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_lsz,
    input  logic              chk_valid,
    input  logic              chk_clear,
    input  logic              chk_nonspec,
    input  logic [REG_W-1:0]  chk_rid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [SIZE_W-1:0] chk_lsz,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [SIZE_W-1:0] snoop_lsz,
    input  logic              inv_valid,
    input  logic [REG_W-1:0]  inv_rid,
    output logic              rsp_valid,
    output logic              rsp_skip
);
    localparam int N  = NUM_ENTRIES;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
        return (p == IW'(N - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [N-1:0]          slot_v;
    tag_t [N-1:0]          slot_tag;
    logic [N-1:0]          m_chk, m_inv, m_alc, m_snp;
    logic [N-1:0]          v_nxt, ld_a, ld_b;
    logic [N-1:0]          v1, v2, v3, hit_vec, same_b;
    logic [N-1:0]          a_oh, b_oh;
    logic                  a_rot, b_rot;
    logic                  chk_hit, a_we, b_we, b_purge;
    logic [IW-1:0]         ptr_q, ptr_b, ptr_nxt;
    tag_t                  tag_a, tag_b;

    assign tag_a = '{rid: chk_rid,   addr: chk_addr,   lsz: chk_lsz};
    assign tag_b = '{rid: alloc_rid, addr: alloc_addr, lsz: alloc_lsz};

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            ldtrack_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .valid_nxt(v_nxt[g]),
                .ld_a     (ld_a[g]),
                .ld_b     (ld_b[g]),
                .tag_a    (tag_a),
                .tag_b    (tag_b),
                .chk_rid  (chk_rid),
                .inv_rid  (inv_rid),
                .alc_rid  (alloc_rid),
                .snp_addr (snoop_addr),
                .snp_lsz  (snoop_lsz),
                .valid_q  (slot_v[g]),
                .tag_q    (slot_tag[g]),
                .m_chk    (m_chk[g]),
                .m_inv    (m_inv[g]),
                .m_alc    (m_alc[g]),
                .m_snp    (m_snp[g])
            );
        end
    endgenerate

    // Stage 1: snoop and invalidate; stage 2: check lookup and clear.
    always_comb begin
        v1 = slot_v;
        if (snoop_valid) v1 = v1 & ~m_snp;
        if (inv_valid)   v1 = v1 & ~m_inv;
        hit_vec = v1 & m_chk;
        chk_hit = chk_valid && !force_miss && (|hit_vec);
        v2 = v1;
        if (chk_valid && chk_clear && chk_hit) v2 = v1 & ~hit_vec;
        a_we = chk_valid && !chk_clear && !chk_hit && !chk_nonspec;
    end

    ldtrack_pick #(.N(N), .IW(IW)) u_pick_chk (
        .live  (v2),
        .same  (v2 & m_chk),
        .ptr   (ptr_q),
        .sel_oh(a_oh),
        .rotate(a_rot)
    );

    // Stage 3: view of the table after the check's allocation.
    always_comb begin
        v3     = a_we ? (v2 | a_oh) : v2;
        same_b = v2 & m_alc;
        if (a_we) begin
            same_b = same_b & ~a_oh;
            if (chk_rid == alloc_rid) same_b = same_b | a_oh;
        end
        ptr_b = (a_we && a_rot) ? ptr_inc(ptr_q) : ptr_q;
    end

    ldtrack_pick #(.N(N), .IW(IW)) u_pick_alc (
        .live  (v3),
        .same  (same_b),
        .ptr   (ptr_b),
        .sel_oh(b_oh),
        .rotate(b_rot)
    );

    // Stage 4: allocate port records or purges.
    always_comb begin
        b_we    = alloc_valid && !alloc_defer;
        b_purge = alloc_valid && alloc_defer;
        if (b_we)
            v_nxt = v3 | b_oh;
        else if (b_purge)
            v_nxt = v3 & ~same_b;
        else
            v_nxt = v3;
        ld_a    = a_we ? a_oh : '0;
        ld_b    = b_we ? b_oh : '0;
        ptr_nxt = (b_we && b_rot) ? ptr_inc(ptr_b) : ptr_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_skip  <= 1'b0;
        end else begin
            ptr_q     <= ptr_nxt;
            rsp_valid <= chk_valid;
            rsp_skip  <= chk_hit;
        end
    end
endmodule

// File: rtl/ldtrack_table_chk.sv
module ldtrack_table_chk
    import ldtrack_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              force_miss,
    input logic              alloc_valid,
    input logic              alloc_defer,
    input logic [REG_W-1:0]  alloc_rid,
    input logic              chk_valid,
    input logic              chk_clear,
    input logic [REG_W-1:0]  chk_rid,
    input logic              snoop_valid,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic [SIZE_W-1:0] snoop_lsz,
    input logic              inv_valid,
    input logic [REG_W-1:0]  inv_rid,
    input logic              rsp_valid,
    input logic              rsp_skip,
    input logic [N-1:0]      ent_valid,
    input tag_t [N-1:0]      ent_tag
);
    logic [REG_W-1:0]  q_alloc_rid, q_chk_rid, q_inv_rid;
    logic [ADDR_W-1:0] q_snp_addr;
    logic [SIZE_W-1:0] q_snp_lsz;
    logic live_alloc, live_chk, live_inv, live_snp, dup;

    always_ff @(posedge clk) begin
        q_alloc_rid <= alloc_rid;
        q_chk_rid   <= chk_rid;
        q_inv_rid   <= inv_rid;
        q_snp_addr  <= snoop_addr;
        q_snp_lsz   <= snoop_lsz;
    end

    always_comb begin
        live_alloc = 1'b0;
        live_chk   = 1'b0;
        live_inv   = 1'b0;
        live_snp   = 1'b0;
        dup        = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ent_valid[i]) begin
                if (ent_tag[i].rid == q_alloc_rid) live_alloc = 1'b1;
                if (ent_tag[i].rid == q_chk_rid)   live_chk   = 1'b1;
                if (ent_tag[i].rid == q_inv_rid)   live_inv   = 1'b1;
                if (ranges_meet(ent_tag[i].addr, ent_tag[i].lsz, q_snp_addr, q_snp_lsz))
                    live_snp = 1'b1;
                for (int j = i + 1; j < N; j++)
                    if (ent_valid[j] && ent_tag[j].rid == ent_tag[i].rid) dup = 1'b1;
            end
        end
    end

    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> rsp_valid);
    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !rsp_valid);
    // R2
    skip_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_skip |-> rsp_valid);
    // R9
    forced_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && force_miss) |=> !rsp_skip);
    // R12
    one_entry_per_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dup);
    // R4
    defer_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_defer && !(chk_valid && !chk_clear && chk_rid == alloc_rid))
        |=> !live_alloc);
    // R7
    clear_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_clear && !force_miss &&
         !(alloc_valid && !alloc_defer && alloc_rid == chk_rid)) |=> !live_chk);
    // R10
    snoop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && !alloc_valid && !(chk_valid && !chk_clear)) |=> !live_snp);
    // R11
    inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !alloc_valid && !(chk_valid && !chk_clear)) |=> !live_inv);
endmodule

bind ldtrack_table ldtrack_table_chk #(.N(NUM_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_miss (force_miss),
    .alloc_valid(alloc_valid),
    .alloc_defer(alloc_defer),
    .alloc_rid  (alloc_rid),
    .chk_valid  (chk_valid),
    .chk_clear  (chk_clear),
    .chk_rid    (chk_rid),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .snoop_lsz  (snoop_lsz),
    .inv_valid  (inv_valid),
    .inv_rid    (inv_rid),
    .rsp_valid  (rsp_valid),
    .rsp_skip   (rsp_skip),
    .ent_valid  (slot_v),
    .ent_tag    (slot_tag)
);

// File: tb/ldtrack_table_bench.sv
module ldtrack_table_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        force_miss = 1'b0;
    logic        alloc_valid = 1'b0, alloc_defer = 1'b0;
    logic [6:0]  alloc_rid = '0;
    logic [63:0] alloc_addr = '0;
    logic [1:0]  alloc_lsz = '0;
    logic        chk_valid = 1'b0, chk_clear = 1'b0, chk_nonspec = 1'b0;
    logic [6:0]  chk_rid = '0;
    logic [63:0] chk_addr = '0;
    logic [1:0]  chk_lsz = '0;
    logic        snoop_valid = 1'b0;
    logic [63:0] snoop_addr = '0;
    logic [1:0]  snoop_lsz = '0;
    logic        inv_valid = 1'b0;
    logic [6:0]  inv_rid = '0;
    logic        rsp_valid, rsp_skip;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ldtrack_table u_ldtrack_table (.*);

    // Behavioural reference model.
    bit          mv [DEPTH];
    logic [6:0]  mr [DEPTH];
    logic [63:0] ma [DEPTH];
    logic [1:0]  ms [DEPTH];
    int          mptr = 0;
    bit          exp_valid, exp_skip;

    function automatic bit meet(input logic [63:0] a, input logic [1:0] sa,
                                input logic [63:0] b, input logic [1:0] sb);
        logic [64:0] ae, be;
        ae = {1'b0, a} + (65'd1 << sa);
        be = {1'b0, b} + (65'd1 << sb);
        return ({1'b0, a} < be) && ({1'b0, b} < ae);
    endfunction

    task automatic model_record(input logic [6:0] r, input logic [63:0] a, input logic [1:0] s);
        int k = -1;
        for (int i = 0; i < DEPTH; i++) if (k < 0 && mv[i] && mr[i] == r) k = i;
        for (int i = 0; i < DEPTH; i++) if (k < 0 && !mv[i]) k = i;
        if (k < 0) begin
            k = mptr;
            mptr = (mptr + 1) % DEPTH;
        end
        mv[k] = 1; mr[k] = r; ma[k] = a; ms[k] = s;
    endtask

    task automatic model_apply();
        bit hit = 0;
        int hi = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (snoop_valid && mv[i] && meet(ma[i], ms[i], snoop_addr, snoop_lsz)) mv[i] = 0;
            if (inv_valid && mv[i] && mr[i] == inv_rid) mv[i] = 0;
        end
        if (chk_valid) begin
            for (int i = 0; i < DEPTH; i++) if (mv[i] && mr[i] == chk_rid) hi = i;
            hit = (hi >= 0) && !force_miss;
            if (chk_clear && hit) mv[hi] = 0;
            if (!chk_clear && !hit && !chk_nonspec) model_record(chk_rid, chk_addr, chk_lsz);
        end
        if (alloc_valid) begin
            if (alloc_defer) begin
                for (int i = 0; i < DEPTH; i++) if (mv[i] && mr[i] == alloc_rid) mv[i] = 0;
            end else begin
                model_record(alloc_rid, alloc_addr, alloc_lsz);
            end
        end
        exp_valid = chk_valid;
        exp_skip  = chk_valid && hit;
    endtask

    task automatic clear_inputs();
        force_miss = 0; alloc_valid = 0; alloc_defer = 0; chk_valid = 0; chk_clear = 0;
        chk_nonspec = 0; snoop_valid = 0; inv_valid = 0;
    endtask

    // Called at a falling edge with inputs set; compares after the rising edge.
    task automatic cycle(input string tag);
        model_apply();
        @(posedge clk);
        #2;
        checks++;
        if (rsp_valid !== exp_valid || rsp_skip !== exp_skip) begin
            errors++;
            $display("FAIL %s: valid/skip actual=%b/%b expected=%b/%b",
                     tag, rsp_valid, rsp_skip, exp_valid, exp_skip);
        end
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_alloc(input int r, input longint a, input int s, input bit d, input string tag);
        alloc_valid = 1; alloc_defer = d; alloc_rid = 7'(r); alloc_addr = 64'(a); alloc_lsz = 2'(s);
        cycle(tag);
    endtask

    task automatic do_chk(input int r, input bit clr, input bit ns, input string tag);
        chk_valid = 1; chk_clear = clr; chk_nonspec = ns; chk_rid = 7'(r);
        chk_addr = 64'h1000 + 64'(r); chk_lsz = 2'd0;
        cycle(tag);
    endtask

    task automatic do_snoop(input longint a, input int s, input string tag);
        snoop_valid = 1; snoop_addr = 64'(a); snoop_lsz = 2'(s);
        cycle(tag);
    endtask

    task automatic do_inv(input int r, input string tag);
        inv_valid = 1; inv_rid = 7'(r);
        cycle(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mv[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_skip !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset outputs actual=%b%b expected=00", rsp_valid, rsp_skip);
        end
        do_chk(5, 0, 1, "R1");
        // R3, R5
        do_alloc(5, 'h100, 3, 0, "R3");
        do_chk(5, 0, 0, "R3");
        do_chk(5, 0, 0, "R5");
        // R7, R8
        do_chk(5, 1, 0, "R7");
        do_chk(5, 1, 0, "R7");
        do_chk(5, 0, 1, "R8");
        // R6
        do_chk(6, 0, 0, "R6");
        do_chk(6, 0, 1, "R6");
        do_chk(7, 0, 1, "R6");
        do_chk(7, 0, 1, "R6");
        // R9 and forced clear
        force_miss = 1; do_chk(6, 0, 1, "R9");
        do_chk(6, 0, 1, "R9");
        force_miss = 1; do_chk(6, 1, 0, "R8");
        do_chk(6, 0, 1, "R8");
        // R4
        do_alloc(6, 'h600, 0, 1, "R4");
        do_chk(6, 0, 1, "R4");
        // R10 boundaries
        do_alloc(8, 'h200, 2, 0, "R10");
        do_alloc(9, 'h208, 3, 0, "R10");
        do_snoop('h203, 0, "R10");
        do_chk(8, 0, 1, "R10");
        do_chk(9, 0, 1, "R10");
        do_snoop('h204, 2, "R10");
        do_chk(9, 0, 1, "R10");
        do_snoop('h207, 1, "R10");
        do_chk(9, 0, 1, "R10");
        // R11
        do_alloc(10, 'h300, 0, 0, "R11");
        do_alloc(11, 'h310, 0, 0, "R11");
        do_inv(10, "R11");
        do_chk(10, 0, 1, "R11");
        do_chk(11, 0, 1, "R11");
        // R12 overwrite and round-robin replacement
        do_alloc(3, 'h700, 0, 0, "R12");
        do_alloc(3, 'h800, 0, 0, "R12");
        do_snoop('h700, 0, "R12");
        do_chk(3, 0, 1, "R12");
        for (int r = 20; r < 30; r++) do_alloc(r, 64'(r) * 16, 1, 0, "R12");
        for (int r = 20; r < 30; r++) do_chk(r, 0, 1, "R12");
        do_chk(3, 0, 1, "R12");
        // R13 same-cycle ordering
        snoop_valid = 1; snoop_addr = 'h900; snoop_lsz = 0;
        alloc_valid = 1; alloc_rid = 40; alloc_addr = 'h900; alloc_lsz = 0;
        chk_valid = 1; chk_rid = 40; chk_nonspec = 1;
        cycle("R13");
        do_chk(40, 0, 1, "R13");
        chk_valid = 1; chk_clear = 1; chk_rid = 40;
        alloc_valid = 1; alloc_rid = 40; alloc_addr = 'h940;
        cycle("R13");
        do_chk(40, 0, 1, "R13");
        // Mixed traffic, compared on every clock.
        for (int n = 0; n < 600; n++) begin
            force_miss  = ($urandom_range(0, 9) == 0);
            alloc_valid = $urandom_range(0, 1);
            alloc_defer = ($urandom_range(0, 3) == 0);
            alloc_rid   = 7'($urandom_range(0, 11));
            alloc_addr  = 64'($urandom_range(0, 63));
            alloc_lsz   = 2'($urandom_range(0, 3));
            chk_valid   = $urandom_range(0, 1);
            chk_clear   = $urandom_range(0, 1);
            chk_nonspec = ($urandom_range(0, 3) == 0);
            chk_rid     = 7'($urandom_range(0, 11));
            chk_addr    = 64'($urandom_range(0, 63));
            chk_lsz     = 2'($urandom_range(0, 3));
            snoop_valid = ($urandom_range(0, 3) == 0);
            snoop_addr  = 64'($urandom_range(0, 63));
            snoop_lsz   = 2'($urandom_range(0, 3));
            inv_valid   = ($urandom_range(0, 5) == 0);
            inv_rid     = 7'($urandom_range(0, 11));
            cycle("R13");
        end
        finish_run();
    end
endmodule